// File: doc/BRIEF.md
# Queue Doorbell Pointer Manager

This block holds the ring pointers for a set of circular submission and completion queues that live in host memory. Host register writes that land in a doorbell window are decoded into submission-tail and completion-head updates. Writes that are malformed or that point at nothing are dropped without any response. Each completion queue also carries a phase tag, which a consumer uses to tell new entries from stale ones.

A queue-setup port creates and deletes queues. The completion engine advances a completion tail with a per-queue post strobe, and the command fetcher advances a submission head with a per-queue pop strobe. In return the block reports which submission queues are empty, which completion queues are full, and the phase bits. It also gives single-cycle pulses: one when a submission queue has work, one when a full completion queue gains room, and an interrupt request. Any queue's four pointers can be read through a read port selected by `rd_qid`.

Queue 0 is the admin pair. It comes up by itself one cycle after reset or disable ends, with `ADM_ENT` entries, interrupts enabled, and its submission side attached to completion queue 0.

Top module: `qdb_ptr`

## Requirements
- R1: After reset, every submission queue reads empty, no completion queue reads full, completion queue 0 shows phase 1, and queues other than 0 do not exist. The admin pair is valid from the second cycle on.
- R2: A write to byte address 0x1000+8q sets the tail of submission queue q. A write to 0x1004+8q sets the head of completion queue q. Only data bits 15:0 are used as the pointer value.
- R3: A doorbell write is dropped, changing no pointer and raising no pulse, if it is misaligned (address bits 1:0 not zero), lies below 0x1000, lies at or beyond 0x1000+8*NQ, targets a queue that does not exist, or carries a value at or above that queue's size.
- R4: An accepted submission tail write raises `sq_kick[q]` for exactly one cycle, in the cycle after the write.
- R5: The create size field is zero-based, so the stored size is the field plus 1. A create is rejected if the size field is 0 or above `MAXE` (0x7FF), if the id is 0, or if the queue already exists. A submission create is also rejected unless its attached completion id is nonzero and that completion queue exists.
- R6: A delete of id 0 is rejected. A completion delete is rejected while a valid submission queue is attached to it. A delete that succeeds clears the queue's pointers.
- R7: A new completion queue starts with phase 1 and both pointers at 0. A post strobe advances the tail by one modulo the size, and a post to a full queue is ignored. The phase bit inverts when the tail wraps from size-1 to 0.
- R8: A completion queue is full when (tail+1) mod size equals head. A submission queue is empty when head equals tail; a queue that does not exist also reads as empty.
- R9: An accepted completion head write to a queue that was full before the write raises `cq_restart[q]` in the next cycle. In that same cycle it raises `sq_kick` for every valid submission queue attached to q.
- R10: An accepted completion head write raises `cq_irq[q]` in the next cycle when interrupts are enabled for q and the new head differs from the tail.
- R11: A pop strobe advances a non-empty submission head by one modulo the size. A pop on an empty queue is ignored.
- R12: While `ctl_off` is high, all queues are invalid, all pointers are zero and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| ctl_off | input | 1 | controller disable; clears all queue state |
| wr_vld | input | 1 | register write strobe |
| wr_addr | input | AW | register byte address |
| wr_data | input | 32 | register write data |
| cfg_vld | input | 1 | queue setup strobe |
| cfg_cq | input | 1 | 1 selects a completion queue, 0 a submission queue |
| cfg_del | input | 1 | 1 deletes, 0 creates |
| cfg_qid | input | QW | queue id |
| cfg_qsize | input | 16 | zero-based queue size |
| cfg_cqid | input | QW | completion queue attached to a new submission queue |
| cfg_ien | input | 1 | interrupt enable for a new completion queue |
| post | input | NQ | per-completion-queue post strobe |
| pop | input | NQ | per-submission-queue fetch strobe |
| rd_qid | input | QW | queue selected by the read port |
| rd_sq_head | output | PW | submission head of rd_qid |
| rd_sq_tail | output | PW | submission tail of rd_qid |
| rd_cq_head | output | PW | completion head of rd_qid |
| rd_cq_tail | output | PW | completion tail of rd_qid |
| sq_empty | output | NQ | submission queue empty flags |
| cq_full | output | NQ | completion queue full flags |
| cq_phase | output | NQ | completion queue phase tags |
| sq_kick | output | NQ | work-pending pulses |
| cq_restart | output | NQ | full-queue-gained-room pulses |
| cq_irq | output | NQ | interrupt request pulses |

## Verification
The bench targets these corner cases:
- The off-by-one size limit, where a pointer value equal to the size must be dropped. A design that compares with greater-than would accept it and corrupt the tail.
- A completion queue that fills up, takes one more post, and is then relieved by a head write. A design that evaluates fullness after the update would miss the restart pulse and the kick to the attached submission queues.
- The tail wrap, which must flip the phase tag exactly once.
- The 0x7FF / 0x800 size boundary and the attached-queue delete rule, which are checked by whether a later post moves the tail.
- Misaligned, out-of-window and oversized writes, mixed at random with pops against a bench-side pointer model.

// File: rtl/qdb_ptr.sv
module qdb_ptr #(
  parameter int NQ = 64,
  parameter int MAXE = 2047,
  parameter int ADM_ENT = 16,
  parameter int AW = 16,
  parameter logic [15:0] DB_BASE = 16'h1000,
  localparam int QW = $clog2(NQ),
  localparam int PW = $clog2(MAXE + 1),
  localparam int SW = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_off,
  input  logic          wr_vld,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          cfg_vld,
  input  logic          cfg_cq,
  input  logic          cfg_del,
  input  logic [QW-1:0] cfg_qid,
  input  logic [15:0]   cfg_qsize,
  input  logic [QW-1:0] cfg_cqid,
  input  logic          cfg_ien,
  input  logic [NQ-1:0] post,
  input  logic [NQ-1:0] pop,
  input  logic [QW-1:0] rd_qid,
  output logic [PW-1:0] rd_sq_head,
  output logic [PW-1:0] rd_sq_tail,
  output logic [PW-1:0] rd_cq_head,
  output logic [PW-1:0] rd_cq_tail,
  output logic [NQ-1:0] sq_empty,
  output logic [NQ-1:0] cq_full,
  output logic [NQ-1:0] cq_phase,
  output logic [NQ-1:0] sq_kick,
  output logic [NQ-1:0] cq_restart,
  output logic [NQ-1:0] cq_irq
);
  logic [NQ-1:0] sv, cv, cien, cph;
  logic [PW-1:0] sh [NQ];
  logic [PW-1:0] st [NQ];
  logic [PW-1:0] ch [NQ];
  logic [PW-1:0] ct [NQ];
  logic [SW-1:0] ssz [NQ];
  logic [SW-1:0] csz [NQ];
  logic [QW-1:0] scq [NQ];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p, input logic [SW-1:0] sz);
    logic [SW-1:0] q;
    q = {1'b0, p} + SW'(1);
    return (q == sz) ? '0 : q[PW-1:0];
  endfunction

  for (genvar i = 0; i < NQ; i++) begin : g_flag
    assign sq_empty[i] = !sv[i] || sh[i] == st[i];
    assign cq_full[i]  = cv[i] && nxt(ct[i], csz[i]) == ch[i];
  end
  assign cq_phase = cph;

  wire [AW-1:0] off  = wr_addr - AW'(DB_BASE);
  wire          hit  = wr_vld && wr_addr[1:0] == 2'b00 && wr_addr >= AW'(DB_BASE)
                       && off < AW'(NQ * 8);
  wire          odd  = off[2];
  wire [QW-1:0] wq   = off[QW+2:3];
  wire [15:0]   np   = wr_data[15:0];
  wire          sq_ok = hit && !odd && sv[wq] && {{(16-SW){1'b0}}, ssz[wq]} > np;
  wire          cq_ok = hit && odd && cv[wq] && {{(16-SW){1'b0}}, csz[wq]} > np;
  wire          rs_hit = cq_ok && cq_full[wq];

  wire sz_ok = cfg_qsize != 16'd0 && cfg_qsize <= 16'(MAXE);
  wire id_ok = cfg_vld && cfg_qid != '0;
  logic cq_busy;
  always_comb begin
    cq_busy = 1'b0;
    for (int i = 0; i < NQ; i++)
      if (sv[i] && scq[i] == cfg_qid) cq_busy = 1'b1;
  end
  wire sqc_ok = id_ok && !cfg_cq && !cfg_del && !sv[cfg_qid] && sz_ok
                && cfg_cqid != '0 && cv[cfg_cqid];
  wire cqc_ok = id_ok && cfg_cq && !cfg_del && !cv[cfg_qid] && sz_ok;
  wire sqd_ok = id_ok && !cfg_cq && cfg_del && sv[cfg_qid];
  wire cqd_ok = id_ok && cfg_cq && cfg_del && cv[cfg_qid] && !cq_busy;
  wire [SW-1:0] new_sz = cfg_qsize[SW-1:0] + SW'(1);

  always_ff @(posedge clk) begin
    if (rst || ctl_off) begin
      sv <= '0; cv <= '0; cien <= '0; cph <= '0;
      sq_kick <= '0; cq_restart <= '0; cq_irq <= '0;
      for (int i = 0; i < NQ; i++) begin
        sh[i] <= '0; st[i] <= '0; ch[i] <= '0; ct[i] <= '0;
        ssz[i] <= '0; csz[i] <= '0; scq[i] <= '0;
      end
    end else if (!cv[0]) begin
      sv[0] <= 1'b1; cv[0] <= 1'b1; cien[0] <= 1'b1; cph[0] <= 1'b1;
      ssz[0] <= SW'(ADM_ENT); csz[0] <= SW'(ADM_ENT); scq[0] <= '0;
    end else begin
      for (int i = 0; i < NQ; i++) begin
        sq_kick[i]    <= (sq_ok && wq == QW'(i)) || (rs_hit && sv[i] && scq[i] == wq);
        cq_restart[i] <= rs_hit && wq == QW'(i);
        cq_irq[i]     <= cq_ok && wq == QW'(i) && cien[i] && np[PW-1:0] != ct[i];

        if (sqc_ok && cfg_qid == QW'(i)) begin
          sv[i] <= 1'b1; sh[i] <= '0; st[i] <= '0; ssz[i] <= new_sz; scq[i] <= cfg_cqid;
        end else if (sqd_ok && cfg_qid == QW'(i)) begin
          sv[i] <= 1'b0; sh[i] <= '0; st[i] <= '0;
        end else begin
          if (sq_ok && wq == QW'(i)) st[i] <= np[PW-1:0];
          if (pop[i] && !sq_empty[i]) sh[i] <= nxt(sh[i], ssz[i]);
        end

        if (cqc_ok && cfg_qid == QW'(i)) begin
          cv[i] <= 1'b1; ch[i] <= '0; ct[i] <= '0; csz[i] <= new_sz;
          cph[i] <= 1'b1; cien[i] <= cfg_ien;
        end else if (cqd_ok && cfg_qid == QW'(i)) begin
          cv[i] <= 1'b0; ch[i] <= '0; ct[i] <= '0; cph[i] <= 1'b0;
        end else begin
          if (cq_ok && wq == QW'(i)) ch[i] <= np[PW-1:0];
          if (post[i] && cv[i] && !cq_full[i]) begin
            ct[i] <= nxt(ct[i], csz[i]);
            if (nxt(ct[i], csz[i]) == '0) cph[i] <= ~cph[i];
          end
        end
      end
    end
  end

  assign rd_sq_head = sh[rd_qid];
  assign rd_sq_tail = st[rd_qid];
  assign rd_cq_head = ch[rd_qid];
  assign rd_cq_tail = ct[rd_qid];
endmodule

// File: rtl/qdb_ptr_chk.sv
module qdb_ptr_chk #(
  parameter int NQ = 64,
  parameter int MAXE = 2047,
  localparam int QW = $clog2(NQ),
  localparam int PW = $clog2(MAXE + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          ctl_off,
  input logic          wr_vld,
  input logic          cfg_vld,
  input logic [NQ-1:0] post,
  input logic [QW-1:0] rd_qid,
  input logic [PW-1:0] rd_cq_tail,
  input logic [NQ-1:0] sq_empty,
  input logic [NQ-1:0] cq_full,
  input logic [NQ-1:0] sq_kick,
  input logic [NQ-1:0] cq_restart,
  input logic [NQ-1:0] cq_irq
);
  p_off_clears_r12: assert property (@(posedge clk) disable iff (rst)
    ctl_off |=> (sq_empty == '1 && cq_full == '0 && sq_kick == '0 && cq_restart == '0 && cq_irq == '0));

  p_restart_from_full_r9: assert property (@(posedge clk) disable iff (rst)
    (cq_restart & ~$past(cq_full)) == '0);

  p_restart_single_r9: assert property (@(posedge clk) disable iff (rst) $onehot0(cq_restart));

  p_irq_single_r10: assert property (@(posedge clk) disable iff (rst) $onehot0(cq_irq));

  p_kick_needs_write_r4: assert property (@(posedge clk) disable iff (rst)
    (sq_kick != '0) |-> $past(wr_vld));

  p_full_holds_tail_r7: assert property (@(posedge clk) disable iff (rst)
    (cq_full[rd_qid] && !wr_vld && !cfg_vld && !ctl_off) ##1 $stable(rd_qid)
    |-> $stable(rd_cq_tail));
endmodule

bind qdb_ptr qdb_ptr_chk #(.NQ(NQ), .MAXE(MAXE)) u_chk (
  .clk(clk), .rst(rst), .ctl_off(ctl_off), .wr_vld(wr_vld), .cfg_vld(cfg_vld),
  .post(post), .rd_qid(rd_qid), .rd_cq_tail(rd_cq_tail), .sq_empty(sq_empty),
  .cq_full(cq_full), .sq_kick(sq_kick), .cq_restart(cq_restart), .cq_irq(cq_irq)
);

// File: tb/tb_qdb_ptr.sv
`timescale 1ns/1ps
module tb_qdb_ptr;
  localparam int NQ = 64;
  logic clk = 0, rst = 1, ctl_off = 0;
  logic wr_vld = 0; logic [15:0] wr_addr = 0; logic [31:0] wr_data = 0;
  logic cfg_vld = 0, cfg_cq = 0, cfg_del = 0, cfg_ien = 0;
  logic [5:0] cfg_qid = 0, cfg_cqid = 0, rd_qid = 0;
  logic [15:0] cfg_qsize = 0;
  logic [NQ-1:0] post = 0, pop = 0;
  logic [10:0] rd_sq_head, rd_sq_tail, rd_cq_head, rd_cq_tail;
  logic [NQ-1:0] sq_empty, cq_full, cq_phase, sq_kick, cq_restart, cq_irq;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  qdb_ptr dut (.*);

  function automatic logic [63:0] bit_of(input int q);
    return 64'(1) << q;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic dbw(input logic [15:0] a, input logic [31:0] d);
    wr_vld = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_vld = 0;
  endtask

  task automatic cfg(input logic cq, input logic del, input int qid, input int qs,
                     input int cqid, input logic ien);
    cfg_vld = 1; cfg_cq = cq; cfg_del = del; cfg_qid = 6'(qid);
    cfg_qsize = 16'(qs); cfg_cqid = 6'(cqid); cfg_ien = ien;
    @(negedge clk);
    cfg_vld = 0;
  endtask

  task automatic do_post(input int q);
    post = bit_of(q); @(negedge clk); post = 0;
  endtask

  task automatic do_pop(input int q);
    pop = bit_of(q); @(negedge clk); pop = 0;
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    int mh, mt;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 empty after reset", sq_empty, '1);
    chk("R1 full after reset", cq_full, '0);
    @(negedge clk);
    chk("R1 admin phase", cq_phase[0], 1);
    rd_qid = 0;
    chk("R1 admin ptrs", {rd_sq_tail, rd_cq_tail}, 0);
    dbw(16'h1000 + 16'd40, 32'd1);
    chk("R1 sq5 absent", sq_kick, 0);

    cfg(1, 0, 1, 3, 0, 1);
    chk("R7 new cq phase", cq_phase[1], 1);
    cfg(0, 0, 2, 7, 1, 0);
    cfg(0, 0, 3, 3, 1, 0);

    cfg(1, 0, 5, 0, 0, 1); do_post(5); rd_qid = 5;
    chk("R5 size zero rejected", rd_cq_tail, 0);
    cfg(1, 0, 8, 16'h800, 0, 1); do_post(8); rd_qid = 8;
    chk("R5 size 0x800 rejected", rd_cq_tail, 0);
    cfg(1, 0, 7, 16'h7FF, 0, 1); do_post(7); rd_qid = 7;
    chk("R5 size 0x7FF accepted", rd_cq_tail, 1);
    do_post(0); cfg(1, 0, 0, 3, 0, 1); rd_qid = 0;
    chk("R5 id 0 create rejected", rd_cq_tail, 1);
    cfg(0, 0, 4, 3, 9, 0); dbw(16'h1020, 32'd1);
    chk("R5 sq needs cq", sq_kick, 0);

    dbw(16'h1010, 32'hABCD_0005);
    chk("R4 kick sq2", sq_kick, bit_of(2));
    rd_qid = 2;
    chk("R2 sq2 tail low16", rd_sq_tail, 5);
    chk("R8 sq2 not empty", sq_empty[2], 0);
    dbw(16'h1012, 32'd1);
    chk("R3 misaligned", {sq_kick, 5'(rd_sq_tail)}, 5);
    dbw(16'h1010, 32'd8);
    chk("R3 value equals size", {sq_kick, 5'(rd_sq_tail)}, 5);
    dbw(16'h0010, 32'd1);
    chk("R3 below window", {sq_kick, 5'(rd_sq_tail)}, 5);
    dbw(16'h1200, 32'd1);
    chk("R3 beyond window", {sq_kick, cq_irq}, 0);

    repeat (5) do_pop(2);
    chk("R11 sq2 drained", {sq_empty[2], 3'(rd_sq_head)}, {1'b1, 3'd5});
    do_pop(2);
    chk("R11 pop empty ignored", rd_sq_head, 5);

    rd_qid = 1;
    repeat (3) do_post(1);
    chk("R8 cq1 full", {cq_full[1], 2'(rd_cq_tail)}, {1'b1, 2'd3});
    do_post(1);
    chk("R7 post on full ignored", rd_cq_tail, 3);
    dbw(16'h100C, 32'd2);
    chk("R9 restart cq1", cq_restart, bit_of(1));
    chk("R9 kick attached sqs", sq_kick, bit_of(2) | bit_of(3));
    chk("R10 irq cq1", cq_irq, bit_of(1));
    chk("R2 cq1 head", rd_cq_head, 2);
    do_post(1);
    chk("R7 wrap flips phase", {cq_phase[1], 2'(rd_cq_tail)}, 0);
    dbw(16'h100C, 32'd0);
    chk("R10 no irq when head equals tail", {cq_irq, cq_restart}, 0);

    cfg(1, 0, 6, 3, 0, 0); do_post(6); dbw(16'h1034, 32'd0);
    chk("R10 irq disabled", cq_irq, 0);

    cfg(1, 1, 1, 0, 0, 0); do_post(1); rd_qid = 1;
    chk("R6 busy cq delete rejected", rd_cq_tail, 1);
    cfg(0, 1, 2, 0, 0, 0); cfg(0, 1, 3, 0, 0, 0); cfg(1, 1, 1, 0, 0, 0);
    do_post(1);
    chk("R6 cq1 deleted", {cq_phase[1], 2'(rd_cq_tail)}, 0);
    cfg(1, 1, 0, 0, 0, 0); do_post(0); rd_qid = 0;
    chk("R6 id 0 delete rejected", rd_cq_tail, 2);

    cfg(0, 0, 10, 15, 6, 0);
    rd_qid = 10; mh = 0; mt = 0;
    for (int k = 0; k < 300; k++) begin
      if ($urandom % 3 == 0) begin
        do_pop(10);
        if (mh != mt) mh = (mh + 1) % 16;
        chk("R11 random pop", rd_sq_head, 11'(mh));
      end else begin
        int v = $urandom % 24;
        int o = ($urandom % 4 == 0) ? int'($urandom % 4) : 0;
        logic ok = (o == 0) && (v < 16);
        dbw(16'h1050 + 16'(o), 32'($urandom) & 32'hFFFF_0000 | 32'(v));
        if (ok) mt = v;
        chk("R3 random kick", sq_kick, ok ? bit_of(10) : 0);
        chk("R2 random tail", rd_sq_tail, 11'(mt));
      end
    end

    ctl_off = 1; @(negedge clk);
    chk("R12 disabled", {cq_phase, cq_full, ~sq_empty}, 0);
    ctl_off = 0; @(negedge clk); @(negedge clk);
    rd_qid = 10; dbw(16'h1050, 32'd1);
    chk("R12 queues gone", {sq_kick, rd_sq_tail}, 0);
    chk("R1 admin back", cq_phase[0], 1);
    summary();
  end
endmodule